// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Unit

This block gives one processing node load-linked and store-conditional under a write-invalidate coherence policy. It also contains the matching decision logic at the home directory. On a load-linked, the node records the line address and sets a single reservation flag. The load-linked only reads the line. It never claims ownership, so two nodes that alternate load-linked pairs cannot take a line from each other without end. While the flag is set, the node watches invalidations and evictions. Any of them that hits the recorded line clears the flag.

A store-conditional is settled in one of two places. When there is no matching live reservation, the node fails it at once. When the reservation is live and the local cache holds the line exclusive, the node lets it succeed at once. In every other case the request goes to the home side. The home side reads the directory entry for the line through a request/acknowledge handshake.

- If the entry shows the line as shared, home grants the store. It writes the entry back as exclusive with the requester as the only holder, and it sends an invalidation to every other sharer.
- If the entry shows the line as uncached or exclusive, home rejects the store.

The network and the data storage are outside the block and are reached only through these handshakes.

Top module: `llsc_reservation_unit`

## Requirements
- R1: After reset, `cpu_ready` is 1, and `cpu_done`, `dir_rd_valid`, `dir_wr_valid` and `inv_valid` are 0. No reservation is held after reset, so a store-conditional issued before any load-linked fails, even with `cpu_line_excl` = 1.
- R2: Operations are encoded `cpu_op` = 0 for load-linked and 1 for store-conditional. A load-linked accepted at clock edge E raises `cpu_done` for the cycle after E, with `cpu_sc_ok` = 0. A store-conditional to the same line that follows with `cpu_line_excl` = 1 then completes one cycle after acceptance with `cpu_sc_ok` = 1, and no directory lookup is made.
- R3: A store-conditional fails locally if no reservation is held or if its address differs from the reserved address. It then raises `cpu_done` with `cpu_sc_ok` = 0 one cycle after acceptance, and no directory lookup follows.
- R4: A store-conditional with a live matching reservation and `cpu_line_excl` = 0 starts a directory lookup. `dir_rd_valid` rises two cycles after acceptance, carrying the store's line address on `dir_rd_addr`. Both stay steady until `dir_rd_ack` is sampled high.
- R5: Directory states are encoded 0 = uncached, 1 = shared, 2 = exclusive. If the acknowledged state is anything other than shared, no directory write or invalidation is issued. `cpu_done` with `cpu_sc_ok` = 0 follows two cycles after the acknowledge edge.
- R6: If the acknowledged state is shared, `dir_wr_valid` pulses in the cycle after the acknowledge edge. The pulse carries state 2 and a holder mask with only bit `NODE_ID` set. In the same cycle `inv_valid` pulses if any sharer other than `NODE_ID` exists, with `inv_mask` equal to the acknowledged sharer mask with bit `NODE_ID` cleared. `cpu_done` with `cpu_sc_ok` = 1 follows one cycle later.
- R7: An invalidation or eviction (`drop_valid`) whose `drop_addr` equals the reserved address clears the reservation. A later store-conditional to that line then fails locally. A drop to any other address leaves the reservation intact. A drop in the same cycle as a load-linked to the same line leaves no reservation.
- R8: Every store-conditional clears the reservation when it completes, whether it succeeds or fails. A second store-conditional without a new load-linked fails locally.
- R9: A load-linked never starts a directory lookup or a directory write. Only a store-conditional reaches the home side.
- R10: `cpu_ready` is 0 from the cycle after a store-conditional is forwarded until the cycle in which its `cpu_done` is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_valid | input | 1 | Processor issues an operation |
| cpu_op | input | 1 | 0 = load-linked, 1 = store-conditional |
| cpu_addr | input | ADDR_W | Line address of the operation |
| cpu_line_excl | input | 1 | Local cache holds the line exclusive |
| drop_valid | input | 1 | Incoming invalidation or local eviction |
| drop_addr | input | ADDR_W | Line address of the drop |
| cpu_ready | output | 1 | Unit can accept an operation |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_sc_ok | output | 1 | Store-conditional succeeded (valid with cpu_done) |
| dir_rd_valid | output | 1 | Home directory lookup request |
| dir_rd_addr | output | ADDR_W | Line address looked up |
| dir_rd_ack | input | 1 | Directory entry supplied this cycle |
| dir_rd_state | input | 2 | Directory state of the line |
| dir_rd_sharers | input | NUM_NODES | Nodes holding a copy |
| dir_wr_valid | output | 1 | Directory write pulse |
| dir_wr_addr | output | ADDR_W | Line address written |
| dir_wr_state | output | 2 | New directory state |
| dir_wr_sharers | output | NUM_NODES | New holder mask |
| inv_valid | output | 1 | Invalidation broadcast pulse |
| inv_addr | output | ADDR_W | Line to invalidate |
| inv_mask | output | NUM_NODES | Nodes that must invalidate |

## Verification
The properties assume that `cpu_valid` is raised only while `cpu_ready` is high. They also assume that `dir_rd_ack` is high only while `dir_rd_valid` is, for a single cycle per lookup. A store-conditional's completion delay is assumed to depend only on the acknowledge cycle. The stimulus keeps within these limits in three ways:
- Every operation is issued through a task that first checks `cpu_ready`.
- The acknowledge is raised after zero to two waiting cycles and dropped after one edge.
- The sweeps cover every directory state and sharer mask, so the only variation left is in the inputs.

// File: rtl/llsc_pkg.sv
// Package: shared encodings for the reservation unit.
// Assumes line addresses are already aligned by the cache.
package llsc_pkg;
    typedef enum logic [1:0] {
        DIR_UNCACHED  = 2'd0,
        DIR_SHARED    = 2'd1,
        DIR_EXCLUSIVE = 2'd2
    } dir_state_e;

    localparam logic OP_LL = 1'b0;
    localparam logic OP_SC = 1'b1;
endpackage

// File: rtl/llsc_node_resv.sv
// Node-side reservation: holds one flag and one line address, decides a
// store-conditional locally or forwards it to home and waits for the reply.
// Assumes cpu_valid only while cpu_ready, and resp_valid only while waiting.
module llsc_node_resv
    import llsc_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_valid,
    input  logic              cpu_op,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_line_excl,
    input  logic              drop_valid,
    input  logic [ADDR_W-1:0] drop_addr,
    input  logic              resp_valid,
    input  logic              resp_ok,
    output logic              cpu_ready,
    output logic              cpu_done,
    output logic              cpu_sc_ok,
    output logic              fwd_valid,
    output logic [ADDR_W-1:0] fwd_addr,
    output logic              resv_valid,
    output logic [ADDR_W-1:0] resv_addr
);
    typedef enum logic {N_IDLE, N_WAIT} node_state_e;
    node_state_e state;

    logic accept;
    logic drop_hits_resv;
    logic drop_hits_req;
    logic resv_live;

    // Purpose: decode this cycle's acceptance and reservation match.
    assign accept         = cpu_valid && (state == N_IDLE);
    assign drop_hits_resv = drop_valid && (drop_addr == resv_addr);
    assign drop_hits_req  = drop_valid && (drop_addr == cpu_addr);
    assign resv_live      = resv_valid && !drop_hits_resv && (resv_addr == cpu_addr);
    assign cpu_ready      = (state == N_IDLE);

    // Purpose: reservation update, local decision and wait for home reply.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= N_IDLE;
            cpu_done   <= 1'b0;
            cpu_sc_ok  <= 1'b0;
            fwd_valid  <= 1'b0;
            fwd_addr   <= '0;
            resv_valid <= 1'b0;
            resv_addr  <= '0;
        end else begin
            cpu_done  <= 1'b0;
            fwd_valid <= 1'b0;
            if (drop_hits_resv) begin
                resv_valid <= 1'b0;
            end
            case (state)
                N_IDLE: begin
                    if (accept) begin
                        if (cpu_op == OP_LL) begin
                            resv_addr  <= cpu_addr;
                            resv_valid <= !drop_hits_req;
                            cpu_done   <= 1'b1;
                            cpu_sc_ok  <= 1'b0;
                        end else if (!resv_live || cpu_line_excl) begin
                            cpu_done   <= 1'b1;
                            cpu_sc_ok  <= resv_live;
                            resv_valid <= 1'b0;
                        end else begin
                            fwd_valid <= 1'b1;
                            fwd_addr  <= cpu_addr;
                            state     <= N_WAIT;
                        end
                    end
                end
                N_WAIT: begin
                    if (resp_valid) begin
                        cpu_done   <= 1'b1;
                        cpu_sc_ok  <= resp_ok;
                        resv_valid <= 1'b0;
                        state      <= N_IDLE;
                    end
                end
                default: state <= N_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/llsc_home_dir.sv
// Home-side decision: looks up the directory entry of a forwarded
// store-conditional, grants it only when the line is shared, and then
// writes the entry exclusive and invalidates the other sharers.
// Assumes dir_rd_ack is high only while dir_rd_valid is high.
module llsc_home_dir
    import llsc_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int NUM_NODES = 4,
    parameter int NODE_ID   = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fwd_valid,
    input  logic [ADDR_W-1:0]    fwd_addr,
    output logic                 dir_rd_valid,
    output logic [ADDR_W-1:0]    dir_rd_addr,
    input  logic                 dir_rd_ack,
    input  logic [1:0]           dir_rd_state,
    input  logic [NUM_NODES-1:0] dir_rd_sharers,
    output logic                 dir_wr_valid,
    output logic [ADDR_W-1:0]    dir_wr_addr,
    output logic [1:0]           dir_wr_state,
    output logic [NUM_NODES-1:0] dir_wr_sharers,
    output logic                 inv_valid,
    output logic [ADDR_W-1:0]    inv_addr,
    output logic [NUM_NODES-1:0] inv_mask,
    output logic                 resp_valid,
    output logic                 resp_ok
);
    localparam logic [NUM_NODES-1:0] SELF_MASK = NUM_NODES'(1) << NODE_ID;

    typedef enum logic {H_IDLE, H_LOOK} home_state_e;
    home_state_e       hstate;
    logic [ADDR_W-1:0] req_addr;
    logic [NUM_NODES-1:0] others;
    logic              grant;

    // Purpose: decision terms from the acknowledged directory entry.
    assign grant  = (dir_rd_state == DIR_SHARED);
    assign others = dir_rd_sharers & ~SELF_MASK;

    // Purpose: drive request addresses and the fixed ownership write value.
    assign dir_rd_valid   = (hstate == H_LOOK);
    assign dir_rd_addr    = req_addr;
    assign dir_wr_addr    = req_addr;
    assign inv_addr       = req_addr;
    assign dir_wr_state   = DIR_EXCLUSIVE;
    assign dir_wr_sharers = SELF_MASK;

    // Purpose: lookup sequencing and one-cycle result pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hstate       <= H_IDLE;
            req_addr     <= '0;
            resp_valid   <= 1'b0;
            resp_ok      <= 1'b0;
            dir_wr_valid <= 1'b0;
            inv_valid    <= 1'b0;
            inv_mask     <= '0;
        end else begin
            resp_valid   <= 1'b0;
            dir_wr_valid <= 1'b0;
            inv_valid    <= 1'b0;
            case (hstate)
                H_IDLE: begin
                    if (fwd_valid) begin
                        req_addr <= fwd_addr;
                        hstate   <= H_LOOK;
                    end
                end
                H_LOOK: begin
                    if (dir_rd_ack) begin
                        resp_valid   <= 1'b1;
                        resp_ok      <= grant;
                        dir_wr_valid <= grant;
                        inv_valid    <= grant && (others != '0);
                        inv_mask     <= others;
                        hstate       <= H_IDLE;
                    end
                end
                default: hstate <= H_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/llsc_reservation_unit.sv
// Top: one node's load-linked/store-conditional reservation joined to the
// home directory decision for its forwarded store-conditionals.
// Assumes the processor waits for cpu_ready and the directory answers once.
module llsc_reservation_unit #(
    parameter int ADDR_W    = 8,
    parameter int NUM_NODES = 4,
    parameter int NODE_ID   = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cpu_valid,
    input  logic                 cpu_op,
    input  logic [ADDR_W-1:0]    cpu_addr,
    input  logic                 cpu_line_excl,
    input  logic                 drop_valid,
    input  logic [ADDR_W-1:0]    drop_addr,
    output logic                 cpu_ready,
    output logic                 cpu_done,
    output logic                 cpu_sc_ok,
    output logic                 dir_rd_valid,
    output logic [ADDR_W-1:0]    dir_rd_addr,
    input  logic                 dir_rd_ack,
    input  logic [1:0]           dir_rd_state,
    input  logic [NUM_NODES-1:0] dir_rd_sharers,
    output logic                 dir_wr_valid,
    output logic [ADDR_W-1:0]    dir_wr_addr,
    output logic [1:0]           dir_wr_state,
    output logic [NUM_NODES-1:0] dir_wr_sharers,
    output logic                 inv_valid,
    output logic [ADDR_W-1:0]    inv_addr,
    output logic [NUM_NODES-1:0] inv_mask
);
    logic              fwd_valid;
    logic [ADDR_W-1:0] fwd_addr;
    logic              resp_valid;
    logic              resp_ok;
    logic              resv_valid;
    logic [ADDR_W-1:0] resv_addr;

    llsc_node_resv #(.ADDR_W(ADDR_W)) u_node (
        .clk(clk), .rst_n(rst_n),
        .cpu_valid(cpu_valid), .cpu_op(cpu_op), .cpu_addr(cpu_addr),
        .cpu_line_excl(cpu_line_excl),
        .drop_valid(drop_valid), .drop_addr(drop_addr),
        .resp_valid(resp_valid), .resp_ok(resp_ok),
        .cpu_ready(cpu_ready), .cpu_done(cpu_done), .cpu_sc_ok(cpu_sc_ok),
        .fwd_valid(fwd_valid), .fwd_addr(fwd_addr),
        .resv_valid(resv_valid), .resv_addr(resv_addr)
    );

    llsc_home_dir #(.ADDR_W(ADDR_W), .NUM_NODES(NUM_NODES), .NODE_ID(NODE_ID)) u_home (
        .clk(clk), .rst_n(rst_n),
        .fwd_valid(fwd_valid), .fwd_addr(fwd_addr),
        .dir_rd_valid(dir_rd_valid), .dir_rd_addr(dir_rd_addr),
        .dir_rd_ack(dir_rd_ack), .dir_rd_state(dir_rd_state),
        .dir_rd_sharers(dir_rd_sharers),
        .dir_wr_valid(dir_wr_valid), .dir_wr_addr(dir_wr_addr),
        .dir_wr_state(dir_wr_state), .dir_wr_sharers(dir_wr_sharers),
        .inv_valid(inv_valid), .inv_addr(inv_addr), .inv_mask(inv_mask),
        .resp_valid(resp_valid), .resp_ok(resp_ok)
    );
endmodule

// File: rtl/llsc_reservation_checker.sv
// Checker: temporal properties of the reservation unit, bound to its top.
// Assumes the input protocol given in the brief.
module llsc_reservation_checker
    import llsc_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int NUM_NODES = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cpu_valid,
    input logic                 cpu_op,
    input logic                 cpu_ready,
    input logic                 cpu_done,
    input logic                 cpu_sc_ok,
    input logic                 drop_valid,
    input logic [ADDR_W-1:0]    drop_addr,
    input logic                 fwd_valid,
    input logic                 resv_valid,
    input logic [ADDR_W-1:0]    resv_addr,
    input logic                 dir_rd_valid,
    input logic [ADDR_W-1:0]    dir_rd_addr,
    input logic                 dir_rd_ack,
    input logic [1:0]           dir_rd_state,
    input logic                 dir_wr_valid,
    input logic                 inv_valid,
    input logic [NUM_NODES-1:0] inv_mask
);
    logic take_ll;
    logic take_sc;
    assign take_ll = cpu_valid && cpu_ready && (cpu_op == OP_LL);
    assign take_sc = cpu_valid && cpu_ready && (cpu_op == OP_SC);

    p_sc_fail_local_r3: assert property (@(posedge clk) disable iff (!rst_n)
        take_sc && !resv_valid |=> cpu_done && !cpu_sc_ok);

    p_rd_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dir_rd_valid && !dir_rd_ack |=> dir_rd_valid && $stable(dir_rd_addr));

    p_reject_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dir_rd_valid && dir_rd_ack && (dir_rd_state != DIR_SHARED)
        |=> (!dir_wr_valid && !inv_valid) ##1 (cpu_done && !cpu_sc_ok));

    p_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dir_rd_valid && dir_rd_ack && (dir_rd_state == DIR_SHARED)
        |=> dir_wr_valid ##1 (cpu_done && cpu_sc_ok));

    p_inv_nonempty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |-> (inv_mask != '0) && dir_wr_valid);

    p_drop_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        drop_valid && (drop_addr == resv_addr) && !take_ll |=> !resv_valid);

    p_sc_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done && cpu_sc_ok |-> !resv_valid);

    p_ll_no_home_r9: assert property (@(posedge clk) disable iff (!rst_n)
        take_ll |=> !fwd_valid);

    p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> !cpu_ready);
endmodule

bind llsc_reservation_unit llsc_reservation_checker #(
    .ADDR_W(ADDR_W), .NUM_NODES(NUM_NODES)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cpu_valid), .cpu_op(cpu_op), .cpu_ready(cpu_ready),
    .cpu_done(cpu_done), .cpu_sc_ok(cpu_sc_ok),
    .drop_valid(drop_valid), .drop_addr(drop_addr),
    .fwd_valid(fwd_valid), .resv_valid(resv_valid), .resv_addr(resv_addr),
    .dir_rd_valid(dir_rd_valid), .dir_rd_addr(dir_rd_addr),
    .dir_rd_ack(dir_rd_ack), .dir_rd_state(dir_rd_state),
    .dir_wr_valid(dir_wr_valid), .inv_valid(inv_valid), .inv_mask(inv_mask)
);

// File: tb/llsc_reservation_unit_test.sv
module llsc_reservation_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int NN = 4;
    localparam int ME = 1;
    localparam logic [NN-1:0] ME_MASK = 4'b0010;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_valid = 1'b0, cpu_op = 1'b0, cpu_line_excl = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic drop_valid = 1'b0;
    logic [AW-1:0] drop_addr = '0;
    logic dir_rd_ack = 1'b0;
    logic [1:0] dir_rd_state = 2'd0;
    logic [NN-1:0] dir_rd_sharers = '0;
    logic cpu_ready, cpu_done, cpu_sc_ok;
    logic dir_rd_valid, dir_wr_valid, inv_valid;
    logic [AW-1:0] dir_rd_addr, dir_wr_addr, inv_addr;
    logic [1:0] dir_wr_state;
    logic [NN-1:0] dir_wr_sharers, inv_mask;

    int checks = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    llsc_reservation_unit #(.ADDR_W(AW), .NUM_NODES(NN), .NODE_ID(ME)) uut (
        .clk(clk), .rst_n(rst_n),
        .cpu_valid(cpu_valid), .cpu_op(cpu_op), .cpu_addr(cpu_addr),
        .cpu_line_excl(cpu_line_excl),
        .drop_valid(drop_valid), .drop_addr(drop_addr),
        .cpu_ready(cpu_ready), .cpu_done(cpu_done), .cpu_sc_ok(cpu_sc_ok),
        .dir_rd_valid(dir_rd_valid), .dir_rd_addr(dir_rd_addr),
        .dir_rd_ack(dir_rd_ack), .dir_rd_state(dir_rd_state),
        .dir_rd_sharers(dir_rd_sharers),
        .dir_wr_valid(dir_wr_valid), .dir_wr_addr(dir_wr_addr),
        .dir_wr_state(dir_wr_state), .dir_wr_sharers(dir_wr_sharers),
        .inv_valid(inv_valid), .inv_addr(inv_addr), .inv_mask(inv_mask)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Issue one operation; returns at the negedge after the accepting edge.
    task automatic issue(input logic op, input logic [AW-1:0] a, input logic excl);
        @(negedge clk);
        check("R10 ready before issue", int'(cpu_ready), 1);
        cpu_valid = 1'b1; cpu_op = op; cpu_addr = a; cpu_line_excl = excl;
        @(negedge clk);
        cpu_valid = 1'b0;
    endtask

    // Operation decided at the node: done one cycle later, no lookup after.
    task automatic local_op(input string tag, input logic op, input logic [AW-1:0] a,
                            input logic excl, input logic exp_ok);
        issue(op, a, excl);
        check({tag, " done"}, int'(cpu_done), 1);
        check({tag, " ok"}, int'(cpu_sc_ok), int'(exp_ok));
        @(negedge clk);
        check({tag, " no lookup"}, int'(dir_rd_valid), 0);
        check({tag, " no dir write"}, int'(dir_wr_valid), 0);
    endtask

    task automatic drop(input logic [AW-1:0] a);
        @(negedge clk);
        drop_valid = 1'b1; drop_addr = a;
        @(negedge clk);
        drop_valid = 1'b0;
    endtask

    // Store-conditional forwarded to home, answered after 'hold' waiting cycles.
    task automatic home_sc(input logic [AW-1:0] a, input int st, input int sh, input int hold);
        logic grant;
        logic [NN-1:0] others;
        grant = (st == 1);
        others = NN'(sh) & ~ME_MASK;
        issue(1'b1, a, 1'b0);
        check("R4 no lookup before second edge", int'(dir_rd_valid), 0);
        @(negedge clk);
        check("R4 lookup raised", int'(dir_rd_valid), 1);
        check("R4 lookup address", int'(dir_rd_addr), int'(a));
        check("R10 busy while forwarded", int'(cpu_ready), 0);
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            check("R4 lookup held", int'(dir_rd_valid), 1);
            check("R4 address held", int'(dir_rd_addr), int'(a));
        end
        dir_rd_ack = 1'b1; dir_rd_state = 2'(st); dir_rd_sharers = NN'(sh);
        @(negedge clk);
        dir_rd_ack = 1'b0;
        check(grant ? "R6 dir write" : "R5 no dir write", int'(dir_wr_valid), int'(grant));
        check(grant ? "R6 inv pulse" : "R5 no inv", int'(inv_valid),
              int'(grant && (others != '0)));
        if (grant) begin
            check("R6 written state", int'(dir_wr_state), 2);
            check("R6 written holders", int'(dir_wr_sharers), int'(ME_MASK));
            check("R6 write address", int'(dir_wr_addr), int'(a));
            if (others != '0) begin
                check("R6 inv mask", int'(inv_mask), int'(others));
                check("R6 inv address", int'(inv_addr), int'(a));
            end
        end
        check("R4 lookup released", int'(dir_rd_valid), 0);
        check("R10 not done yet", int'(cpu_done), 0);
        @(negedge clk);
        check(grant ? "R6 done" : "R5 done", int'(cpu_done), 1);
        check(grant ? "R6 success" : "R5 failure", int'(cpu_sc_ok), int'(grant));
        check("R10 ready after done", int'(cpu_ready), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready", int'(cpu_ready), 1);
        check("R1 done", int'(cpu_done), 0);
        check("R1 lookup", int'(dir_rd_valid), 0);
        check("R1 dir write", int'(dir_wr_valid), 0);
        check("R1 inv", int'(inv_valid), 0);
        local_op("R1 sc with no reservation", 1'b1, 8'h10, 1'b1, 1'b0);

        // Local success and clearing on completion, over many lines.
        for (int a = 0; a < 16; a++) begin
            local_op("R2 ll", 1'b0, AW'(a * 7), 1'b0, 1'b0);
            local_op("R2 sc exclusive", 1'b1, AW'(a * 7), 1'b1, 1'b1);
            local_op("R8 second sc", 1'b1, AW'(a * 7), 1'b1, 1'b0);
        end

        // Address mismatch fails locally.
        for (int a = 0; a < 8; a++) begin
            local_op("R3 ll", 1'b0, AW'(a), 1'b0, 1'b0);
            local_op("R3 sc other line", 1'b1, AW'(a ^ 1), 1'b1, 1'b0);
        end

        // Drops: matching, non-matching, same cycle as load-linked.
        for (int a = 0; a < 8; a++) begin
            local_op("R7 ll", 1'b0, AW'(a + 32), 1'b0, 1'b0);
            drop(AW'(a + 33));
            local_op("R7 unrelated drop kept", 1'b1, AW'(a + 32), 1'b1, 1'b1);
            local_op("R7 ll again", 1'b0, AW'(a + 32), 1'b0, 1'b0);
            drop(AW'(a + 32));
            local_op("R7 matching drop cleared", 1'b1, AW'(a + 32), 1'b1, 1'b0);
        end
        @(negedge clk);
        drop_valid = 1'b1; drop_addr = 8'h55;
        cpu_valid = 1'b1; cpu_op = 1'b0; cpu_addr = 8'h55; cpu_line_excl = 1'b0;
        @(negedge clk);
        drop_valid = 1'b0; cpu_valid = 1'b0;
        check("R7 ll with drop done", int'(cpu_done), 1);
        local_op("R7 same-cycle drop", 1'b1, 8'h55, 1'b1, 1'b0);

        // Home sweep: every directory state and sharer mask.
        for (int st = 0; st < 4; st++) begin
            for (int sh = 0; sh < 16; sh++) begin
                local_op("R9 ll", 1'b0, AW'(st * 16 + sh), 1'b0, 1'b0);
                home_sc(AW'(st * 16 + sh), st, sh, sh % 3);
                local_op("R8 sc after home", 1'b1, AW'(st * 16 + sh), 1'b1, 1'b0);
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule